// File: doc/BRIEF.md
# Constant-Time Montgomery Ladder Sequencer

This block runs the control side of an x-only Montgomery ladder for elliptic-curve scalar multiplication over a prime field. A single-cycle start pulse hands it the scalar and the affine x-coordinate of the base point. It keeps the two ladder accumulators in projective X/Z form and walks the scalar from its top bit down. For each bit it launches one point addition and one point doubling on two external point units in the same cycle. It collects both results and writes them back into the accumulators.

The scalar bit affects only which accumulator feeds the doubler and where each result is written. Both choices are made with mask-based selects, so there are no data-dependent branches. Every iteration waits for both units before it commits, and the sequence of handshakes is the same for every key. After the last bit the block asks an external stage to convert both accumulators to affine form, then asks a second stage to recover y. It pulses done when that stage finishes. The arithmetic inside the point units, the conversion and the recovery are not part of this block.

Top module: `mladder_seq`

## Requirements
- R1: After reset, busy, done and all four start strobes (add_go, dbl_go, aff_go, yrec_go) are 0.
- R2: An accepted start sets accumulator A to the point at infinity (X=1, Z=0) and accumulator B to the base point (X=base_x, Z=1).
- R3: Each run issues exactly KW iterations. In every iteration add_go and dbl_go are one-cycle pulses raised in the same cycle.
- R4: Bits are used from bit KW-1 down to bit 0. The adder always receives A as operand a and B as operand b. The doubler receives A when the bit is 0 and B when the bit is 1.
- R5: On commit, a 0 bit writes the doubled point into A and the sum into B. A 1 bit writes the sum into A and the doubled point into B.
- R6: The accumulators do not change between an iteration's start strobes and the later of its two unit completions.
- R7: The number of cycles from start to done does not depend on the scalar value.
- R8: After the last commit, aff_go pulses while the q outputs hold the final accumulators. yrec_go pulses only after aff_done. done pulses one cycle after yrec_done.
- R9: busy stays high from an accepted start until done. A start while busy is ignored and does not change the scalar being processed.
- R10: The ladder keeps B equal to A plus the base point. With additive stand-in units (sum = a+b, double = 2a on each coordinate), A's Z ends at k and B's Z ends at k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, accepted only while idle |
| scalar | input | KW | Scalar k |
| base_x | input | FW | Affine x of the base point |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| add_go | output | 1 | Start strobe for the addition unit |
| add_ax | output | FW | Addition operand a, X |
| add_az | output | FW | Addition operand a, Z |
| add_bx | output | FW | Addition operand b, X |
| add_bz | output | FW | Addition operand b, Z |
| add_done | input | 1 | Addition unit completion pulse |
| add_rx | input | FW | Sum X, valid with add_done |
| add_rz | input | FW | Sum Z, valid with add_done |
| dbl_go | output | 1 | Start strobe for the doubling unit |
| dbl_x | output | FW | Doubling operand X |
| dbl_z | output | FW | Doubling operand Z |
| dbl_done | input | 1 | Doubling unit completion pulse |
| dbl_rx | input | FW | Doubled X, valid with dbl_done |
| dbl_rz | input | FW | Doubled Z, valid with dbl_done |
| aff_go | output | 1 | Request to convert both accumulators to affine form |
| aff_done | input | 1 | Conversion finished |
| yrec_go | output | 1 | Request for y recovery |
| yrec_done | input | 1 | Recovery finished |
| q0x | output | FW | Accumulator A, X |
| q0z | output | FW | Accumulator A, Z |
| q1x | output | FW | Accumulator B, X |
| q1z | output | FW | Accumulator B, Z |

## Verification
The bench builds the block with KW=8 and FW=16. That keeps runs short enough to cover all-zero, all-one, single-top-bit and alternating scalars, and every multiple k+1 fits in a coordinate without wrapping, so R10 can be read straight off the Z words. The stand-in addition unit takes 5 cycles and the doubler takes 3. Their completions therefore arrive in different cycles, which exercises the rule that the block waits for both before it commits. A start pulse injected in the middle of a run shows that a busy block ignores it.

// File: rtl/mlad_pkg.sv
package mlad_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_COMMIT,
    ST_AFF,
    ST_YREC
  } mlad_state_e;

  localparam int unsigned NCOORD = 2; // X then Z
endpackage

// File: rtl/mlad_csel.sv
// Mask-based two-way select: no branch depends on sel.
module mlad_csel #(
  parameter int unsigned W = 256
) (
  input  logic         sel,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  logic [W-1:0] m;
  always_comb begin
    m = {W{sel}};
    y = (a & ~m) | (b & m);
  end
endmodule

// File: rtl/mlad_bitctr.sv
// Scalar bit index, counts from KW-1 down to 0.
module mlad_bitctr #(
  parameter int unsigned KW = 256,
  localparam int unsigned IW = (KW > 1) ? $clog2(KW) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          dec,
  output logic [IW-1:0] idx,
  output logic          last
);
  always_ff @(posedge clk) begin
    if (rst)       idx <= '0;
    else if (load) idx <= IW'(KW - 1);
    else if (dec)  idx <= idx - 1'b1;
  end
  assign last = (idx == '0);
endmodule

// File: rtl/mladder_seq.sv
module mladder_seq
  import mlad_pkg::*;
#(
  parameter int unsigned KW = 256,
  parameter int unsigned FW = 256,
  localparam int unsigned IW = (KW > 1) ? $clog2(KW) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [KW-1:0] scalar,
  input  logic [FW-1:0] base_x,
  output logic          busy,
  output logic          done,
  output logic          add_go,
  output logic [FW-1:0] add_ax,
  output logic [FW-1:0] add_az,
  output logic [FW-1:0] add_bx,
  output logic [FW-1:0] add_bz,
  input  logic          add_done,
  input  logic [FW-1:0] add_rx,
  input  logic [FW-1:0] add_rz,
  output logic          dbl_go,
  output logic [FW-1:0] dbl_x,
  output logic [FW-1:0] dbl_z,
  input  logic          dbl_done,
  input  logic [FW-1:0] dbl_rx,
  input  logic [FW-1:0] dbl_rz,
  output logic          aff_go,
  input  logic          aff_done,
  output logic          yrec_go,
  input  logic          yrec_done,
  output logic [FW-1:0] q0x,
  output logic [FW-1:0] q0z,
  output logic [FW-1:0] q1x,
  output logic [FW-1:0] q1z
);
  mlad_state_e st;
  logic [KW-1:0] key_r;
  logic [NCOORD-1:0][FW-1:0] q0, q1, sum_r, dbl_r;
  logic [NCOORD-1:0][FW-1:0] dop, nq0, nq1;
  logic a_seen, d_seen;
  logic [IW-1:0] idx;
  logic last, cur_bit, ld_idx, dec_idx;

  assign ld_idx  = (st == ST_IDLE) && start;
  assign dec_idx = (st == ST_COMMIT) && !last;

  mlad_bitctr #(.KW(KW)) u_ctr (
    .clk(clk), .rst(rst), .load(ld_idx), .dec(dec_idx), .idx(idx), .last(last)
  );

  assign cur_bit = key_r[idx];

  // Per-coordinate selects: doubler operand and both write-back paths
  for (genvar c = 0; c < NCOORD; c++) begin : g_coord
    mlad_csel #(.W(FW)) u_dsel (.sel(cur_bit), .a(q0[c]),    .b(q1[c]),    .y(dop[c]));
    mlad_csel #(.W(FW)) u_w0   (.sel(cur_bit), .a(dbl_r[c]), .b(sum_r[c]), .y(nq0[c]));
    mlad_csel #(.W(FW)) u_w1   (.sel(cur_bit), .a(sum_r[c]), .b(dbl_r[c]), .y(nq1[c]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE;
      key_r <= '0;
      q0 <= '0; q1 <= '0; sum_r <= '0; dbl_r <= '0;
      a_seen <= 1'b0; d_seen <= 1'b0;
      busy <= 1'b0; done <= 1'b0;
      add_go <= 1'b0; dbl_go <= 1'b0; aff_go <= 1'b0; yrec_go <= 1'b0;
      add_ax <= '0; add_az <= '0; add_bx <= '0; add_bz <= '0;
      dbl_x <= '0; dbl_z <= '0;
    end else begin
      add_go <= 1'b0; dbl_go <= 1'b0; aff_go <= 1'b0; yrec_go <= 1'b0;
      done <= 1'b0;
      unique case (st)
        ST_IDLE: if (start) begin
          key_r <= scalar;
          q0[0] <= FW'(1);  q0[1] <= '0;
          q1[0] <= base_x;  q1[1] <= FW'(1);
          busy <= 1'b1;
          st <= ST_ISSUE;
        end
        ST_ISSUE: begin
          add_ax <= q0[0]; add_az <= q0[1];
          add_bx <= q1[0]; add_bz <= q1[1];
          dbl_x <= dop[0]; dbl_z <= dop[1];
          add_go <= 1'b1; dbl_go <= 1'b1;
          a_seen <= 1'b0; d_seen <= 1'b0;
          st <= ST_WAIT;
        end
        ST_WAIT: begin
          if (add_done) begin
            sum_r <= {add_rz, add_rx};
            a_seen <= 1'b1;
          end
          if (dbl_done) begin
            dbl_r <= {dbl_rz, dbl_rx};
            d_seen <= 1'b1;
          end
          if ((a_seen || add_done) && (d_seen || dbl_done)) st <= ST_COMMIT;
        end
        ST_COMMIT: begin
          q0 <= nq0;
          q1 <= nq1;
          if (last) begin
            aff_go <= 1'b1;
            st <= ST_AFF;
          end else begin
            st <= ST_ISSUE;
          end
        end
        ST_AFF: if (aff_done) begin
          yrec_go <= 1'b1;
          st <= ST_YREC;
        end
        ST_YREC: if (yrec_done) begin
          done <= 1'b1;
          busy <= 1'b0;
          st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign q0x = q0[0];
  assign q0z = q0[1];
  assign q1x = q1[0];
  assign q1z = q1[1];

  // Assertions
  assert_go_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    add_go |=> !add_go && !dbl_go);
  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT) |=> ($stable(q0) && $stable(q1)));
  assert_commit_both_R6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_COMMIT) |-> (a_seen && d_seen));
  assert_done_after_yrec_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(yrec_done));
  assert_quiet_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !(add_go || dbl_go || aff_go || yrec_go));
  assert_busy_rise_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
endmodule

// File: tb/test_mladder_seq.sv
module test_mladder_seq;
  localparam int KW = 8;
  localparam int FW = 16;
  localparam int LAT_ADD = 5;
  localparam int LAT_DBL = 3;
  localparam int LAT_AFF = 4;
  localparam int LAT_YR  = 2;

  logic clk = 0, rst = 1, start = 0;
  logic [KW-1:0] scalar = '0;
  logic [FW-1:0] base_x = '0;
  logic busy, done, add_go, dbl_go, aff_go, yrec_go;
  logic [FW-1:0] add_ax, add_az, add_bx, add_bz, dbl_x, dbl_z;
  logic add_done, dbl_done, aff_done, yrec_done;
  logic [FW-1:0] add_rx, add_rz, dbl_rx, dbl_rz;
  logic [FW-1:0] q0x, q0z, q1x, q1z;

  always #5 clk = ~clk;

  mladder_seq #(.KW(KW), .FW(FW)) i_mladder_seq (
    .clk(clk), .rst(rst), .start(start), .scalar(scalar), .base_x(base_x),
    .busy(busy), .done(done),
    .add_go(add_go), .add_ax(add_ax), .add_az(add_az), .add_bx(add_bx), .add_bz(add_bz),
    .add_done(add_done), .add_rx(add_rx), .add_rz(add_rz),
    .dbl_go(dbl_go), .dbl_x(dbl_x), .dbl_z(dbl_z),
    .dbl_done(dbl_done), .dbl_rx(dbl_rx), .dbl_rz(dbl_rz),
    .aff_go(aff_go), .aff_done(aff_done), .yrec_go(yrec_go), .yrec_done(yrec_done),
    .q0x(q0x), .q0z(q0z), .q1x(q1x), .q1z(q1z)
  );

  // Behavioural stand-in units with fixed latencies
  int ca = 0, cd = 0, cf = 0, cy = 0;
  always @(posedge clk) begin
    if (rst) begin ca <= 0; cd <= 0; cf <= 0; cy <= 0; end
    else begin
      if (add_go) begin ca <= LAT_ADD; add_rx <= add_ax + add_bx; add_rz <= add_az + add_bz; end
      else if (ca != 0) ca <= ca - 1;
      if (dbl_go) begin cd <= LAT_DBL; dbl_rx <= dbl_x << 1; dbl_rz <= dbl_z << 1; end
      else if (cd != 0) cd <= cd - 1;
      if (aff_go) cf <= LAT_AFF; else if (cf != 0) cf <= cf - 1;
      if (yrec_go) cy <= LAT_YR; else if (cy != 0) cy <= cy - 1;
    end
  end
  assign add_done  = (ca == 1);
  assign dbl_done  = (cd == 1);
  assign aff_done  = (cf == 1);
  assign yrec_done = (cy == 1);

  int errors = 0, checks = 0;
  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference model, evaluated on every falling edge
  bit m_act = 0, a_pend = 0, d_pend = 0, aff_seen = 0;
  int it = 0, cyc = 0, ref_cyc = -1, go_n = 0;
  logic [KW-1:0] mk;
  logic [FW-1:0] m0x, m0z, m1x, m1z, sx, sz, dx, dz, s0x, s0z, s1x, s1z;
  logic mb;

  always @(negedge clk) begin
    if (!rst) begin
      if (start && !busy && !m_act) begin
        m_act = 1; mk = scalar; it = 0; cyc = 0; aff_seen = 0;
        m0x = 1; m0z = 0; m1x = base_x; m1z = 1;
      end
      if (m_act) cyc++;
      if (add_go || dbl_go) begin
        chk(add_go == dbl_go, "R3 add/dbl same cycle", add_go, dbl_go);
        chk(busy == 1'b1, "R9 busy during ladder", busy, 1);
        mb = mk[KW-1-it];
        chk(add_ax == m0x && add_az == m0z, "R4 add operand a", add_ax, m0x);
        chk(add_bx == m1x && add_bz == m1z, "R4 add operand b", add_bx, m1x);
        chk(dbl_x == (mb ? m1x : m0x) && dbl_z == (mb ? m1z : m0z),
            "R4 dbl operand", dbl_x, mb ? m1x : m0x);
        if (it == 0)
          chk(add_az == 0 && add_ax == 1 && add_bz == 1 && add_bx == base_x,
              "R2 initial accumulators", add_az, 0);
        sx = m0x + m1x; sz = m0z + m1z;
        dx = (mb ? m1x : m0x) << 1; dz = (mb ? m1z : m0z) << 1;
        if (mb) begin m0x = sx; m0z = sz; m1x = dx; m1z = dz; end
        else    begin m0x = dx; m0z = dz; m1x = sx; m1z = sz; end
        it++;
        a_pend = 1; d_pend = 1;
        s0x = q0x; s0z = q0z; s1x = q1x; s1z = q1z;
      end else if (a_pend || d_pend) begin
        chk(q0x == s0x && q0z == s0z && q1x == s1x && q1z == s1z,
            "R6 accumulators held while pending", q0z, s0z);
        if (add_done) a_pend = 0;
        if (dbl_done) d_pend = 0;
      end
      if (aff_go) begin
        chk(it == KW, "R3 iteration count", it, KW);
        chk(q0x == m0x && q0z == m0z, "R5 final A", q0x, m0x);
        chk(q1x == m1x && q1z == m1z, "R5 final B", q1x, m1x);
        chk(q0z == FW'(mk), "R10 A.Z equals k", q0z, mk);
        chk(q1z == FW'(mk + 1), "R10 B.Z equals k+1", q1z, mk + 1);
      end
      if (aff_done) aff_seen = 1;
      if (yrec_go) chk(aff_seen, "R8 yrec after aff_done", aff_seen, 1);
      if (done) begin
        m_act = 0;
        chk(busy == 1'b0, "R9 busy clears with done", busy, 0);
        if (ref_cyc < 0) ref_cyc = cyc;
        else chk(cyc == ref_cyc, "R7 key-independent duration", cyc, ref_cyc);
        go_n++;
      end
    end
  end

  task automatic run(input logic [KW-1:0] k, input logic [FW-1:0] bx, input bit poke);
    @(posedge clk); #1;
    scalar = k; base_x = bx; start = 1;
    @(posedge clk); #1;
    start = 0;
    if (poke) begin
      repeat (20) @(posedge clk);
      #1 scalar = ~k; start = 1;
      @(posedge clk); #1 start = 0;
      @(negedge clk);
      chk(busy == 1'b1, "R9 busy stays high after ignored start", busy, 1);
    end
    while (!done) @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!busy && !done && !add_go && !dbl_go && !aff_go && !yrec_go,
        "R1 reset state", {busy, done, add_go, dbl_go, aff_go, yrec_go}, 0);
    #1 rst = 0;
    run(8'h00, 16'd7, 0);
    run(8'h01, 16'd9, 0);
    run(8'hFF, 16'd3, 0);
    run(8'h80, 16'd11, 0);
    run(8'hA5, 16'd5, 0);
    run(8'h5A, 16'd13, 1);
    chk(go_n == 6, "R8 done pulses per run", go_n, 6);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule